// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is a 32-bit processor datapath in which every move goes over one shared bus. A separate controller, not part of this block, drives a set of plain control lines each cycle. Four enables choose which source puts its value on the bus: the immediate extender, the ALU, the register file or the memory read port. The load strobes then choose which registers capture the bus at the next rising edge. These registers are the instruction register, the two ALU operand latches and the memory address register. The register file and memory can also be written from the bus. A step such as "memory address takes the program counter" is one cycle: select the program counter, enable the register file onto the bus, and raise the memory-address load.

The register selector picks the program counter, one of three register-number fields of the instruction register, or the fixed link register 31. Register 0 always reads as zero. Three signals go back to the controller: the opcode field, a flag that is high when the first operand latch is zero, and the memory busy flag. Memory is an external synchronous port. Its address comes only from the memory address register, and its write data is always the bus value. Every port is a plain control or status pin with no handshake. Back-pressure from memory appears only as the busy flag, which the controller must honour by waiting. The datapath itself never stalls.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, the instruction register, both operand latches, the memory address register, the program counter and every general register hold zero.
- R2: The bus equals the value of the one enabled source (`drv_imm`, `drv_alu`, `drv_reg` or `drv_mem`), and zero when none is enabled. At most one enable may be high in a cycle. `mem_wdata_o` always shows the bus, and `mem_we_o` follows `mem_wr` in the same cycle.
- R3: Each of `ld_ir`, `ld_a`, `ld_b` and `ld_ma` makes its register capture the bus at the rising edge. Without its load, a register keeps its value. `mem_addr_o` is the memory address register.
- R4: `reg_sel` encodings are: 0 program counter, 1 general register IR[25:21], 2 general register IR[20:16], 3 general register IR[15:11], 4 general register 31. Codes 5 to 7 read zero and ignore writes. With `reg_wr` high, the selected register takes the bus at the edge.
- R5: General register 0 reads zero, and writes to it are ignored.
- R6: With `ext_sel` at 0, the extender gives IR[15:0] sign-extended to 32 bits. With `ext_sel` at 1, it gives IR[25:0] sign-extended.
- R7: `op_sel` encodings are: 0 applies the operation coded in IR[2:0], 1 applies the operation coded in IR[28:26], 2 gives A+4, 3 gives A+B. The operation codes are: 0 add, 1 subtract A-B, 2 and, 3 or, 4 xor, 5 shift A left by B[4:0], 6 shift A right logically by B[4:0], 7 signed A<B giving 1 or 0. Results wrap modulo 2^32.
- R8: `zero_o` is high exactly when the A latch is zero.
- R9: `opcode_o` is IR[31:26], and `busy_o` is `mem_busy_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_ir | input | 1 | Instruction register takes the bus |
| ld_a | input | 1 | Operand A latch takes the bus |
| ld_b | input | 1 | Operand B latch takes the bus |
| ld_ma | input | 1 | Memory address register takes the bus |
| drv_imm | input | 1 | Extended immediate drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_reg | input | 1 | Selected register drives the bus |
| drv_mem | input | 1 | Memory read data drives the bus |
| reg_wr | input | 1 | Selected register takes the bus |
| mem_wr | input | 1 | Memory write request |
| reg_sel | input | 3 | Register selector |
| ext_sel | input | 1 | Immediate width select |
| op_sel | input | 2 | ALU operation source |
| opcode_o | output | 6 | Opcode field of the instruction register |
| zero_o | output | 1 | A latch is zero |
| busy_o | output | 1 | Memory busy, to the controller |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data (the bus) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Memory read data |
| mem_busy_i | input | 1 | Memory busy |

## Verification
The hardest cases to reach are those where a register-number field aliases another path. One case is a field that points at register 31, which must be the same storage as the link selector. The other is a field that points at register 0, which must swallow writes. Both can only be set up by loading crafted instruction words through the memory read path. The bench does this before the reads, and then reloads the instruction register with swapped fields so that values written under one selector are read back under another. The program-counter increment with wrap-around is reached by loading an operand latch from the program counter or from memory and then sending the ALU result back into the program counter.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 6;

  localparam logic [2:0] RS_PC   = 3'd0;
  localparam logic [2:0] RS_F1   = 3'd1;
  localparam logic [2:0] RS_F2   = 3'd2;
  localparam logic [2:0] RS_F3   = 3'd3;
  localparam logic [2:0] RS_LINK = 3'd4;

  typedef enum logic [1:0] {
    OS_FUNC = 2'd0,
    OS_OPC  = 2'd1,
    OS_INC4 = 2'd2,
    OS_ADD  = 2'd3
  } osel_e;

  typedef enum logic [2:0] {
    AC_ADD = 3'd0,
    AC_SUB = 3'd1,
    AC_AND = 3'd2,
    AC_OR  = 3'd3,
    AC_XOR = 3'd4,
    AC_SLL = 3'd5,
    AC_SRL = 3'd6,
    AC_SLT = 3'd7
  } acode_e;
endpackage

// File: rtl/sbus_immext.sv
module sbus_immext #(
  parameter int W     = 32,
  parameter int NARROW = 16,
  parameter int WIDE   = 26
) (
  input  logic [W-1:0] ir,
  input  logic         ext_sel,
  output logic [W-1:0] imm
);
  always_comb begin
    if (ext_sel) imm = {{(W-WIDE){ir[WIDE-1]}}, ir[WIDE-1:0]};
    else         imm = {{(W-NARROW){ir[NARROW-1]}}, ir[NARROW-1:0]};
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op_sel,
  input  logic [2:0]   func_code,
  input  logic [2:0]   opc_code,
  output logic [W-1:0] y
);
  localparam int SH_W = $clog2(W);

  function automatic logic [W-1:0] apply(input logic [2:0] code,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] z);
    logic [SH_W-1:0] sh;
    sh = z[SH_W-1:0];
    case (acode_e'(code))
      AC_ADD:  apply = x + z;
      AC_SUB:  apply = x - z;
      AC_AND:  apply = x & z;
      AC_OR:   apply = x | z;
      AC_XOR:  apply = x ^ z;
      AC_SLL:  apply = x << sh;
      AC_SRL:  apply = x >> sh;
      default: apply = {{(W-1){1'b0}}, ($signed(x) < $signed(z))};
    endcase
  endfunction

  always_comb begin
    case (osel_e'(op_sel))
      OS_FUNC: y = apply(func_code, a, b);
      OS_OPC:  y = apply(opc_code, a, b);
      OS_INC4: y = a + W'(4);
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
#(
  parameter int W    = 32,
  parameter int NGPR = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              sel,
  input  logic [$clog2(NGPR)-1:0] idx1,
  input  logic [$clog2(NGPR)-1:0] idx2,
  input  logic [$clog2(NGPR)-1:0] idx3,
  input  logic                    wr_en,
  input  logic [W-1:0]            wr_data,
  output logic [W-1:0]            rd_data
);
  localparam int IW = $clog2(NGPR);

  logic [W-1:0]  gpr_q [NGPR];
  logic [W-1:0]  pc_q;
  logic          use_pc, use_gpr;
  logic [IW-1:0] gidx;

  always_comb begin
    use_pc  = 1'b0;
    use_gpr = 1'b0;
    gidx    = '0;
    case (sel)
      RS_PC:   use_pc = 1'b1;
      RS_F1:   begin use_gpr = 1'b1; gidx = idx1; end
      RS_F2:   begin use_gpr = 1'b1; gidx = idx2; end
      RS_F3:   begin use_gpr = 1'b1; gidx = idx3; end
      RS_LINK: begin use_gpr = 1'b1; gidx = IW'(NGPR-1); end
      default: ;
    endcase
  end

  always_comb begin
    if (use_pc)       rd_data = pc_q;
    else if (use_gpr) rd_data = gpr_q[gidx];
    else              rd_data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc_q <= '0;
    else if (wr_en && use_pc)  pc_q <= wr_data;
  end

  for (genvar g = 0; g < NGPR; g++) begin : g_gpr
    if (g == 0) begin : g_zero
      assign gpr_q[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  gpr_q[g] <= '0;
        else if (wr_en && use_gpr && gidx == IW'(g)) gpr_q[g] <= wr_data;
      end
    end
  end

  // R4: the program counter moves only on a write that selects it
  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == RS_PC) |=> $stable(pc_q));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int NGPR = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ir,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_ma,
  input  logic          drv_imm,
  input  logic          drv_alu,
  input  logic          drv_reg,
  input  logic          drv_mem,
  input  logic          reg_wr,
  input  logic          mem_wr,
  input  logic [2:0]    reg_sel,
  input  logic          ext_sel,
  input  logic [1:0]    op_sel,
  output logic [OPC_W-1:0] opcode_o,
  output logic          zero_o,
  output logic          busy_o,
  output logic [W-1:0]  mem_addr_o,
  output logic [W-1:0]  mem_wdata_o,
  output logic          mem_we_o,
  input  logic [W-1:0]  mem_rdata_i,
  input  logic          mem_busy_i
);
  localparam int IW     = $clog2(NGPR);
  localparam int F1_LSB = W - OPC_W - IW;
  localparam int F2_LSB = F1_LSB - IW;
  localparam int F3_LSB = F2_LSB - IW;

  logic [W-1:0] ir_q, a_q, b_q, ma_q;
  logic [W-1:0] bus, imm_v, alu_y, reg_rd;

  assign bus = ({W{drv_imm}} & imm_v) | ({W{drv_alu}} & alu_y) |
               ({W{drv_reg}} & reg_rd) | ({W{drv_mem}} & mem_rdata_i);

  // R2: one bus driver at most in any cycle
  p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({drv_imm, drv_alu, drv_reg, drv_mem}) <= 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir) ir_q <= bus;
      if (ld_a)  a_q  <= bus;
      if (ld_b)  b_q  <= bus;
      if (ld_ma) ma_q <= bus;
    end
  end

  // R3: the memory address holds without its load
  p_ma_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ma |=> $stable(mem_addr_o));

  sbus_regfile #(.W(W), .NGPR(NGPR)) rf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (reg_sel),
    .idx1    (ir_q[F1_LSB +: IW]),
    .idx2    (ir_q[F2_LSB +: IW]),
    .idx3    (ir_q[F3_LSB +: IW]),
    .wr_en   (reg_wr),
    .wr_data (bus),
    .rd_data (reg_rd)
  );

  sbus_immext #(.W(W)) ext_i (
    .ir      (ir_q),
    .ext_sel (ext_sel),
    .imm     (imm_v)
  );

  // R6: narrow immediate has all upper bits equal to its sign bit
  p_ext_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel |-> ($countones(imm_v[W-1:15]) == 0 ||
                  $countones(imm_v[W-1:15]) == W - 15));

  sbus_alu #(.W(W)) alu_i (
    .a         (a_q),
    .b         (b_q),
    .op_sel    (op_sel),
    .func_code (ir_q[2:0]),
    .opc_code  (ir_q[W-4:W-6]),
    .y         (alu_y)
  );

  // R7: the address-add result minus B gives back A
  p_alu_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OS_ADD) |-> (alu_y - b_q == a_q));

  assign opcode_o    = ir_q[W-1 -: OPC_W];
  assign zero_o      = (a_q == '0);
  assign busy_o      = mem_busy_i;
  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = bus;
  assign mem_we_o    = mem_wr;

  // R8: loading a zero bus value into A raises the zero flag
  p_zero_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && bus == '0) |=> zero_o);
endmodule

// File: tb/sbus_datapath_tb_top.sv
module sbus_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_ir, ld_a, ld_b, ld_ma, drv_imm, drv_alu, drv_reg, drv_mem;
  logic reg_wr, mem_wr, ext_sel, mem_busy_i;
  logic [2:0] reg_sel;
  logic [1:0] op_sel;
  logic [5:0] opcode_o;
  logic zero_o, busy_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sbus_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b),
    .ld_ma(ld_ma), .drv_imm(drv_imm), .drv_alu(drv_alu), .drv_reg(drv_reg),
    .drv_mem(drv_mem), .reg_wr(reg_wr), .mem_wr(mem_wr), .reg_sel(reg_sel),
    .ext_sel(ext_sel), .op_sel(op_sel), .opcode_o(opcode_o), .zero_o(zero_o),
    .busy_o(busy_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i), .mem_busy_i(mem_busy_i)
  );

  typedef struct packed {
    logic [1:0]  os;
    logic [2:0]  code;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    '{2'd0, 3'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
    '{2'd0, 3'd2, 32'hF0F0_1234, 32'h0FF0_00FF, 32'h00F0_0034},
    '{2'd0, 3'd3, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F},
    '{2'd0, 3'd4, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
    '{2'd0, 3'd5, 32'h0000_0001, 32'h0000_0021, 32'h0000_0002},
    '{2'd0, 3'd6, 32'h8000_0000, 32'h0000_0004, 32'h0800_0000},
    '{2'd0, 3'd7, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    '{2'd1, 3'd7, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
    '{2'd1, 3'd1, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007},
    '{2'd2, 3'd0, 32'hFFFF_FFFC, 32'h1234_5678, 32'h0000_0000},
    '{2'd3, 3'd0, 32'h0000_1000, 32'h0000_0020, 32'h0000_1020}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    {ld_ir, ld_a, ld_b, ld_ma, drv_imm, drv_alu, drv_reg, drv_mem} = '0;
    {reg_wr, mem_wr, ext_sel} = '0;
    reg_sel = 3'd0;
    op_sel = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // which: 0 IR, 1 A, 2 B, 3 MA
  task automatic mload(input logic [31:0] v, input int which);
    clr();
    mem_rdata_i = v;
    drv_mem = 1'b1;
    case (which)
      0: ld_ir = 1'b1;
      1: ld_a = 1'b1;
      2: ld_b = 1'b1;
      default: ld_ma = 1'b1;
    endcase
    tick();
    clr();
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] v);
    clr();
    mem_rdata_i = v;
    drv_mem = 1'b1;
    reg_wr = 1'b1;
    reg_sel = sel;
    tick();
    clr();
  endtask

  task automatic rreg(input logic [2:0] sel, output logic [31:0] v);
    clr();
    drv_reg = 1'b1;
    reg_sel = sel;
    #1;
    v = mem_wdata_o;
    clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    clr();
    mem_rdata_i = 32'hA5A5_A5A5;
    mem_busy_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 mem_addr", mem_addr_o, 32'h0);
    chk("R1 zero", {31'b0, zero_o}, 32'h1);
    chk("R1 opcode", {26'b0, opcode_o}, 32'h0);
    rreg(3'd0, v); chk("R1 pc", v, 32'h0);
    rreg(3'd4, v); chk("R1 r31", v, 32'h0);

    // R2: idle bus reads zero even with memory data present
    #1; chk("R2 idle bus", mem_wdata_o, 32'h0);

    // R7: ALU vector table
    for (int i = 0; i < NV; i++) begin
      mload(VEC[i].a, 1);
      mload(VEC[i].b, 2);
      mload((VEC[i].os == 2'd1) ? {3'b0, VEC[i].code, 26'b0} : {29'b0, VEC[i].code}, 0);
      drv_alu = 1'b1;
      op_sel = VEC[i].os;
      #1;
      chk($sformatf("R7 vec%0d", i), mem_wdata_o, VEC[i].exp);
      clr();
    end

    // R9: opcode field and busy pass-through
    mload(32'hFC00_0000, 0);
    chk("R9 opcode", {26'b0, opcode_o}, 32'h3F);
    mem_busy_i = 1'b1; #1;
    chk("R9 busy high", {31'b0, busy_o}, 32'h1);
    mem_busy_i = 1'b0; #1;
    chk("R9 busy low", {31'b0, busy_o}, 32'h0);

    // R6: immediate extender
    mload(32'h0000_8001, 0);
    drv_imm = 1'b1; ext_sel = 1'b0; #1; chk("R6 narrow neg", mem_wdata_o, 32'hFFFF_8001);
    ext_sel = 1'b1; #1; chk("R6 wide pos", mem_wdata_o, 32'h0000_8001);
    clr();
    mload(32'h0200_7000, 0);
    drv_imm = 1'b1; ext_sel = 1'b0; #1; chk("R6 narrow pos", mem_wdata_o, 32'h0000_7000);
    ext_sel = 1'b1; #1; chk("R6 wide neg", mem_wdata_o, 32'hFE00_7000);
    clr();

    // R8: zero flag
    mload(32'h0000_0100, 1);
    chk("R8 nonzero", {31'b0, zero_o}, 32'h0);
    mload(32'h0, 1);
    chk("R8 zero", {31'b0, zero_o}, 32'h1);

    // R4: selector paths, rf1=3 rf2=4 rf3=5
    mload({6'd0, 5'd3, 5'd4, 5'd5, 11'd0}, 0);
    wreg(3'd1, 32'h0000_00A1);
    wreg(3'd2, 32'h0000_00B2);
    wreg(3'd3, 32'h0000_00C3);
    wreg(3'd4, 32'h0000_00D4);
    wreg(3'd0, 32'h0000_0040);
    rreg(3'd1, v); chk("R4 rf1", v, 32'h0000_00A1);
    rreg(3'd2, v); chk("R4 rf2", v, 32'h0000_00B2);
    rreg(3'd3, v); chk("R4 rf3", v, 32'h0000_00C3);
    rreg(3'd4, v); chk("R4 link", v, 32'h0000_00D4);
    rreg(3'd0, v); chk("R4 pc", v, 32'h0000_0040);
    wreg(3'd5, 32'h0000_0999);
    rreg(3'd5, v); chk("R4 code5 reads zero", v, 32'h0);
    rreg(3'd0, v); chk("R4 code5 write ignored pc", v, 32'h0000_0040);
    rreg(3'd1, v); chk("R4 code5 write ignored rf1", v, 32'h0000_00A1);
    // rf1=31 rf2=3 rf3=0
    mload({6'd0, 5'd31, 5'd3, 5'd0, 11'd0}, 0);
    rreg(3'd1, v); chk("R4 rf1 aliases link", v, 32'h0000_00D4);
    rreg(3'd2, v); chk("R4 rf2 now r3", v, 32'h0000_00A1);

    // R5: register 0
    rreg(3'd3, v); chk("R5 r0 reads zero", v, 32'h0);
    wreg(3'd3, 32'h0000_DEAD);
    rreg(3'd3, v); chk("R5 r0 write ignored", v, 32'h0);

    // R3: MA <- PC, then PC <- A + 4
    clr(); drv_reg = 1'b1; reg_sel = 3'd0; ld_ma = 1'b1; tick(); clr();
    chk("R3 ma from pc", mem_addr_o, 32'h0000_0040);
    clr(); drv_reg = 1'b1; reg_sel = 3'd0; ld_a = 1'b1; tick(); clr();
    clr(); drv_alu = 1'b1; op_sel = 2'd2; reg_wr = 1'b1; reg_sel = 3'd0; tick(); clr();
    rreg(3'd0, v); chk("R7 pc increment", v, 32'h0000_0044);
    chk("R3 ma held", mem_addr_o, 32'h0000_0040);
    mload(32'h0000_1234, 3);
    chk("R3 ma from mem", mem_addr_o, 32'h0000_1234);

    // R2: memory store path
    clr(); drv_reg = 1'b1; reg_sel = 3'd0; mem_wr = 1'b1; #1;
    chk("R2 write enable", {31'b0, mem_we_o}, 32'h1);
    chk("R2 write data is bus", mem_wdata_o, 32'h0000_0044);
    clr(); #1;
    chk("R2 write enable low", {31'b0, mem_we_o}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule